// File: doc/BRIEF.md
# Programmable Master Clock Divider Controller

This block turns one of four source tick strobes into a chain of clock enables for a processor and a master clock domain. Everything runs on one fast reference clock, and each source is an enable strobe on that clock. A 32-bit configuration word sets three things: which source is used, a processor prescaler, and a master divider. The block drives a processor tick, a master tick and a double-rate master tick. All three are single-cycle enables that qualify the reference clock.

Software changes the configuration one field at a time. A write is refused while the write-protect input is high. A write that alters more than one field is thrown away and raises a sticky error flag. An accepted write that changes a field restarts the divider counters and drops the ready flag. Ready comes back only after the new chain has produced two master periods. Software waits for ready before it changes the next field.

Top module: `mck_divctl`

## Requirements
- R1: After reset, `rd_data` reads 0x00000001, `ready` is 1 and `cfg_err` is 0.
- R2: `rd_data` shows the source code in bits 1:0, the prescaler code in bits 6:4 and the master code in bits 10:8. All other bits read 0, and values written to them have no effect.
- R3: Source code n (0 to 3) selects strobe `src_tick[n]` as the input to the prescaler.
- R4: Prescaler codes 0 to 6 emit one `cpu_tick` for every 1, 2, 4, 8, 16, 32 or 64 selected source ticks. Code 7 emits one for every 3.
- R5: The master code sets how many processor ticks make one `mck_tick`: code 0 = 1, code 1 = 2, code 2 = 4, code 3 = 3. Codes 4 to 7 behave like code 0. Every `mck_tick` coincides with a `cpu_tick`.
- R6: `mck2x_tick` pulses once per processor tick for codes 0 and 1, and once per two processor ticks for code 2. For code 3 it pulses twice per three processor ticks, at gaps of 2 and then 1 processor ticks. Every `mck_tick` coincides with an `mck2x_tick` pulse.
- R7: A write made while `wr_prot` is 1 is ignored. `rd_data` and `cfg_err` keep their values.
- R8: A write that changes more than one field is discarded and sets `cfg_err`. Any later accepted write clears `cfg_err`.
- R9: An accepted write that changes one field drops `ready` on the next cycle. `ready` returns high on the edge that ends the cycle holding the second `mck_tick` after the write. With a source that ticks every cycle, `ready` therefore stays low for 2·P·M cycles, where P is the prescaler ratio and M is the master ratio. An accepted write that changes nothing leaves `ready` alone.
- R10: A field change clears the divider counters. With a source that ticks every cycle, the first `mck_tick` comes P·M cycles after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | 32 | Configuration word to write |
| wr_prot | input | 1 | Write protect; while 1, writes are ignored |
| rd_data | output | 32 | Current configuration word |
| src_tick | input | 4 | Source enable strobes, indexed by source code |
| cpu_tick | output | 1 | Processor clock enable |
| mck_tick | output | 1 | Master clock enable |
| mck2x_tick | output | 1 | Double-rate master clock enable |
| ready | output | 1 | High once the last configuration change has settled |
| cfg_err | output | 1 | Sticky flag for a discarded multi-field write |

## Verification
The register readback, `cfg_err` and the fall of `ready` all change on the edge that samples the write. The bench checks them at the falling edge that follows.

The tick enables are combinational in the selected strobe and the counter state. The bench therefore measures them as gaps between pulses seen at falling edges.

The bench times recovery in falling edges counted from the write edge, with the source ticking every cycle. It expects the first master tick at edge P·M and `ready` low for exactly 2·P·M samples. The rate checks run only once `ready` is high again, so they see settled periods and not the restart.

// File: rtl/mck_pkg.sv
package mck_pkg;
  localparam int REG_W   = 32;
  localparam int SRC_W   = 2;
  localparam int PRE_W   = 3;
  localparam int MD_W    = 3;
  localparam int SRC_LSB = 0;
  localparam int PRE_LSB = 4;
  localparam int MD_LSB  = 8;
  localparam int NSRC    = 1 << SRC_W;
  localparam logic [REG_W-1:0] RST_WORD = 32'h0000_0001;

  typedef struct packed {
    logic [MD_W-1:0]  md;
    logic [PRE_W-1:0] pre;
    logic [SRC_W-1:0] src;
  } cfg_t;

  function automatic cfg_t word_to_cfg(input logic [REG_W-1:0] w);
    cfg_t c;
    c.src = w[SRC_LSB +: SRC_W];
    c.pre = w[PRE_LSB +: PRE_W];
    c.md  = w[MD_LSB  +: MD_W];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] cfg_to_word(input cfg_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[SRC_LSB +: SRC_W] = c.src;
    w[PRE_LSB +: PRE_W] = c.pre;
    w[MD_LSB  +: MD_W]  = c.md;
    return w;
  endfunction

  // processor prescaler ratio: powers of two, with the all-ones code meaning 3
  function automatic int unsigned pre_ratio(input logic [PRE_W-1:0] code);
    if (code == {PRE_W{1'b1}}) return 3;
    return 32'd1 << code;
  endfunction
endpackage

// File: rtl/mck_cfg_reg.sv
module mck_cfg_reg
  import mck_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             wr_prot,
  output cfg_t             cfg,
  output logic             restart,
  output logic             err,
  output logic [REG_W-1:0] rd_data
);
  cfg_t       nxt;
  logic [2:0] diff;
  logic       accept;

  always_comb begin
    nxt     = word_to_cfg(wr_data);
    diff[0] = (nxt.src != cfg.src);
    diff[1] = (nxt.pre != cfg.pre);
    diff[2] = (nxt.md  != cfg.md);
    accept  = wr_en && !wr_prot && ($countones(diff) <= 1);
    restart = accept && (diff != 3'b000);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= word_to_cfg(RST_WORD);
      err <= 1'b0;
    end else if (accept) begin
      cfg <= nxt;
      err <= 1'b0;
    end else if (wr_en && !wr_prot) begin
      err <= 1'b1;
    end
  end

  assign rd_data = cfg_to_word(cfg);
endmodule

// File: rtl/mck_prescale.sv
module mck_prescale
  import mck_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_tick,
  input  logic [SRC_W-1:0] sel,
  input  logic [PRE_W-1:0] code,
  input  logic             clr,
  output logic             pre_tick
);
  logic          tick;
  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  always_comb begin
    tick     = src_tick[sel];
    limit    = CW'(pre_ratio(code) - 1);
    pre_tick = tick && (cnt == limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (tick)    cnt <= (cnt == limit) ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/mck_mdiv.sv
module mck_mdiv
  import mck_pkg::*;
#(
  parameter int CW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pre_tick,
  input  logic [MD_W-1:0] code,
  input  logic            clr,
  output logic            mck_tick,
  output logic            dbl_tick
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  always_comb begin
    case (code)
      MD_W'(1): begin limit = CW'(1); dbl_tick = pre_tick; end
      MD_W'(2): begin limit = CW'(3); dbl_tick = pre_tick && cnt[0]; end
      MD_W'(3): begin limit = CW'(2); dbl_tick = pre_tick && (cnt != '0); end
      default:  begin limit = '0;     dbl_tick = pre_tick; end
    endcase
    mck_tick = pre_tick && (cnt == limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (clr)      cnt <= '0;
    else if (pre_tick) cnt <= (cnt == limit) ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/mck_settle.sv
module mck_settle #(
  parameter int NPER = 2,
  localparam int CW  = (NPER > 1) ? $clog2(NPER) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic mck_tick,
  output logic ready
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready <= 1'b1;
      cnt   <= '0;
    end else if (restart) begin
      ready <= 1'b0;
      cnt   <= '0;
    end else if (!ready && mck_tick) begin
      if (cnt == CW'(NPER - 1)) begin
        ready <= 1'b1;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mck_divctl.sv
module mck_divctl
  import mck_pkg::*;
#(
  parameter int PRE_CW = 6,
  parameter int MD_CW  = 2,
  parameter int NPER   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             wr_prot,
  output logic [REG_W-1:0] rd_data,
  input  logic [NSRC-1:0]  src_tick,
  output logic             cpu_tick,
  output logic             mck_tick,
  output logic             mck2x_tick,
  output logic             ready,
  output logic             cfg_err
);
  cfg_t cfg;
  logic restart;

  mck_cfg_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_prot(wr_prot), .cfg(cfg), .restart(restart), .err(cfg_err),
    .rd_data(rd_data)
  );

  mck_prescale #(.CW(PRE_CW)) u_pre (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .sel(cfg.src),
    .code(cfg.pre), .clr(restart), .pre_tick(cpu_tick)
  );

  mck_mdiv #(.CW(MD_CW)) u_mdiv (
    .clk(clk), .rst_n(rst_n), .pre_tick(cpu_tick), .code(cfg.md),
    .clr(restart), .mck_tick(mck_tick), .dbl_tick(mck2x_tick)
  );

  mck_settle #(.NPER(NPER)) u_settle (
    .clk(clk), .rst_n(rst_n), .restart(restart), .mck_tick(mck_tick),
    .ready(ready)
  );
endmodule

// File: rtl/mck_divctl_chk.sv
module mck_divctl_chk
  import mck_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic             wr_prot,
  input logic [REG_W-1:0] rd_data,
  input logic             cpu_tick,
  input logic             mck_tick,
  input logic             mck2x_tick,
  input logic             ready,
  input logic             cfg_err
);
  cfg_t cur, req;
  int   nd;

  always_comb begin
    cur = word_to_cfg(rd_data);
    req = word_to_cfg(wr_data);
    nd  = 0;
    if (cur.src != req.src) nd = nd + 1;
    if (cur.pre != req.pre) nd = nd + 1;
    if (cur.md  != req.md)  nd = nd + 1;
  end

  a_r7_prot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_prot) |=> ($stable(rd_data) && $stable(cfg_err)));

  a_r8_multi_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_prot && nd > 1) |=> (cfg_err && $stable(rd_data)));

  a_r8_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_prot && nd <= 1) |=> !cfg_err);

  a_r9_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_prot && nd == 1) |=> !ready);

  a_r9_nochange_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_prot && nd == 0 && ready) |=> ready);

  a_r5_mck_on_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    mck_tick |-> cpu_tick);

  a_r6_dbl_on_mck: assert property (@(posedge clk) disable iff (!rst_n)
    mck_tick |-> mck2x_tick);
endmodule

bind mck_divctl mck_divctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .wr_prot(wr_prot), .rd_data(rd_data), .cpu_tick(cpu_tick),
  .mck_tick(mck_tick), .mck2x_tick(mck2x_tick), .ready(ready),
  .cfg_err(cfg_err)
);

// File: tb/tb_mck_divctl.sv
module tb_mck_divctl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        wr_prot = 1'b0;
  logic [31:0] rd_data;
  logic [3:0]  src_tick = 4'b0010;
  logic        cpu_tick, mck_tick, mck2x_tick, ready, cfg_err;

  int n_chk = 0;
  int n_fail = 0;
  int mon_done = 0;
  bit ended = 0;

  typedef struct {
    string tag;
    int    cpu_gap;
    int    mck_gap;
    int    dbl_cnt;
  } exp_t;
  exp_t exp_q[$];

  mck_divctl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_prot(wr_prot), .rd_data(rd_data), .src_tick(src_tick),
    .cpu_tick(cpu_tick), .mck_tick(mck_tick), .mck2x_tick(mck2x_tick),
    .ready(ready), .cfg_err(cfg_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // source strobes: src0 every 5, src1 every cycle, src2 every 2, src3 every 3
  initial begin
    int cyc;
    cyc = 0;
    forever begin
      @(posedge clk);
      #1;
      cyc = cyc + 1;
      src_tick[0] = (cyc % 5 == 0);
      src_tick[1] = 1'b1;
      src_tick[2] = (cyc % 2 == 0);
      src_tick[3] = (cyc % 3 == 0);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // monitor: pops expected rates and measures them at falling edges
  initial begin
    forever begin
      exp_t e;
      int g;
      int d;
      wait (exp_q.size() > 0);
      e = exp_q.pop_front();
      do @(negedge clk); while (!cpu_tick);
      g = 0;
      do begin @(negedge clk); g++; end while (!cpu_tick);
      check({e.tag, " cpu period"}, g, e.cpu_gap);
      do @(negedge clk); while (!mck_tick);
      g = 0;
      do begin @(negedge clk); g++; end while (!mck_tick);
      check({e.tag, " mck period"}, g, e.mck_gap);
      d = 0;
      for (int k = 0; k < 2 * g; k++) begin
        @(negedge clk);
        if (mck2x_tick) d++;
      end
      check({e.tag, " mck2x pulses per two periods"}, d, e.dbl_cnt);
      mon_done++;
    end
  end

  task automatic expect_rates(input string tag, input int cpu, input int mck, input int dbl);
    int n;
    exp_t e;
    n = mon_done;
    e.tag = tag; e.cpu_gap = cpu; e.mck_gap = mck; e.dbl_cnt = dbl;
    exp_q.push_back(e);
    wait (mon_done == n + 1);
  endtask

  task automatic do_write(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  // write a single-field change, then time first master tick and ready recovery
  task automatic write_settle(input string tag, input logic [31:0] d,
                              input int exp_first, input int exp_low);
    int first;
    int low;
    first = -1;
    low = 0;
    do_write(d);
    for (int k = 1; k < 5000; k++) begin
      @(negedge clk);
      if (mck_tick && first < 0) first = k;
      if (ready) break;
      low++;
    end
    check({tag, " R2 readback"}, int'(rd_data), int'(d & 32'h0000_0773));
    if (exp_first >= 0) begin
      check({tag, " R10 first mck tick"}, first, exp_first);
      check({tag, " R9 ready low cycles"}, low, exp_low);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset word", int'(rd_data), 1);
    check("R1 reset ready", int'(ready), 1);
    check("R1 reset err", int'(cfg_err), 0);
    expect_rates("R3 src1 base", 1, 1, 2);

    // R4 prescaler /4, then /3
    write_settle("R4 pre4", 32'h0000_0021, 4, 8);
    expect_rates("R4 pre4", 4, 4, 2);
    write_settle("R4 pre3", 32'h0000_0071, 3, 6);
    expect_rates("R4 pre3", 3, 3, 2);

    // R6 master code 3 (divide by 3, double rate 1.5)
    write_settle("R6 md3", 32'h0000_0371, 9, 18);
    expect_rates("R6 md3", 3, 9, 4);

    // R8 multi-field write discarded
    do_write(32'h0000_0012);
    @(negedge clk);
    check("R8 multi err set", int'(cfg_err), 1);
    check("R8 multi word kept", int'(rd_data), 32'h371);
    check("R8 multi ready kept", int'(ready), 1);

    // R7 write protect
    wr_prot = 1'b1;
    do_write(32'h0000_0370);
    @(negedge clk);
    check("R7 prot word kept", int'(rd_data), 32'h371);
    check("R7 prot err kept", int'(cfg_err), 1);
    wr_prot = 1'b0;

    // R2 unused bits ignored; no-change write clears error, keeps ready
    do_write(32'h0000_0371 | 32'hFFFF_F88C);
    @(negedge clk);
    check("R2 unused bits ignored", int'(rd_data), 32'h371);
    check("R8 err cleared", int'(cfg_err), 0);
    check("R9 no-change keeps ready", int'(ready), 1);

    // R5 master codes 2, 1, 0
    write_settle("R5 md2", 32'h0000_0271, 12, 24);
    expect_rates("R5 md2", 3, 12, 4);
    write_settle("R5 md1", 32'h0000_0171, 6, 12);
    expect_rates("R5 md1", 3, 6, 4);
    write_settle("R5 md0", 32'h0000_0071, 3, 6);
    write_settle("R4 pre1", 32'h0000_0001, 1, 2);

    // R3 other sources
    write_settle("R3 src2", 32'h0000_0002, -1, -1);
    expect_rates("R3 src2", 2, 2, 2);
    write_settle("R3 src3", 32'h0000_0003, -1, -1);
    expect_rates("R3 src3", 3, 3, 2);
    write_settle("R3 src0", 32'h0000_0000, -1, -1);
    expect_rates("R3 src0", 5, 5, 2);
    write_settle("R4 src0 pre2", 32'h0000_0010, -1, -1);
    expect_rates("R4 src0 pre2", 10, 10, 2);

    finish_run();
  end
endmodule